// File: doc/BRIEF.md
# Stripmined Vector Sum Reduction Unit

This block reduces a stream of integer elements to one sum using the two-phase scheme a vector machine uses. Software gives an element count and a chunk width, a power of two up to a build-time maximum. The block streams the elements in over a valid/ready handshake and adds element j of every chunk into partial-sum lane j. Once the whole stream has been consumed, it folds the lanes together by repeated halving until a single lane remains. It then presents that lane as the result.

A reduction starts with a one-cycle start request while the block is idle. All arithmetic wraps modulo 2^DATA_W. The result stays on its output until the consumer accepts it. The block takes no new start request before then, so each result is delivered exactly once.

Top module: `stripSumReduce`

## Requirements
- R1: A start request seen while idle latches cfgCount and cfgLogVl and clears every lane to zero. For a nonzero count, inReady is high from the next cycle.
- R2: Exactly cfgCount elements are taken. Element i, counted from 0, goes to lane i mod VL, where VL = 2^cfgLogVl. Once the last element has been taken, inReady stays low and further inValid has no effect on the result.
- R3: resData equals the sum of all taken elements modulo 2^DATA_W.
- R4: The fold phase takes one cycle per halving. resValid rises exactly cfgLogVl clock edges after the edge that takes the last element. cfgLogVl may be 0 up to log2(VLMAX).
- R5: When the count is not a multiple of VL, the lanes that the short last chunk does not reach contribute zero. Partial sums left over from an earlier reduction never appear in a later result.
- R6: A count of zero takes no element, and the result is 0.
- R7: resValid holds with resData stable until resReady is seen high on a clock edge. resValid is low in the next cycle.
- R8: A start request made while a reduction is in progress or while a result is pending is ignored. It changes neither the count, the chunk width nor the result, and inReady is low while resValid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| startReq | input | 1 | Begin a reduction (taken only when idle) |
| cfgCount | input | CNT_W | Number of elements to reduce |
| cfgLogVl | input | LV_W | log2 of the chunk width VL |
| inValid | input | 1 | Element on inData is valid |
| inData | input | DATA_W | Element value |
| inReady | output | 1 | Block takes an element this cycle |
| resValid | output | 1 | Result available |
| resData | output | DATA_W | Reduced sum |
| resReady | input | 1 | Consumer takes the result |

## Verification
A wrong lane index or a missed lane clear changes resData in that run or the next one, so every run compares the sum against a value computed in the bench. A wrong fold count or a wrong halving distance shows as a latency that differs from cfgLogVl, or as a lane missing from the sum, so the bench measures the latency from the last accepted element. An element counter that is off by one shows as inReady staying high, or dropping, one element too late or too soon. Any of these faults is visible at the ports within one reduction. The bench sweeps every chunk width with counts around each chunk boundary, and it inserts input stalls and stray start pulses.

// File: rtl/stripSumPkg.sv
`timescale 1ns/1ps
package stripSumPkg;
  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic clr;   // zero every lane
    logic acc;   // add inData into the addressed lane
    logic fold;  // halve: lane k += lane k+half
  } sumStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACC,
    ST_FOLD,
    ST_DONE
  } sumState_t;
endpackage

// File: rtl/stripSumCtrl.sv
`timescale 1ns/1ps
module stripSumCtrl
  import stripSumPkg::*;
#(
  parameter int CNT_W = 16,
  parameter int IDX_W = 3,
  parameter int LV_W  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [CNT_W-1:0] cfgCount,
  input  logic [LV_W-1:0]  cfgLogVl,
  input  logic             inValid,
  input  logic             resReady,
  output logic             inReady,
  output logic             resValid,
  output logic             idle,
  output sumStrobe_t       strobe,
  output logic [IDX_W-1:0] lane,
  output logic [LV_W-1:0]  foldLog
);
  sumState_t        state;
  logic [CNT_W-1:0] remain;
  logic [LV_W-1:0]  logVl;
  logic [LV_W-1:0]  logVlEff;
  logic [IDX_W-1:0] laneMask;
  logic             take;

  assign logVlEff = (cfgLogVl > LV_W'(IDX_W)) ? LV_W'(IDX_W) : cfgLogVl;
  assign inReady  = (state == ST_ACC);
  assign resValid = (state == ST_DONE);
  assign idle     = (state == ST_IDLE);
  assign take     = inValid && inReady;

  always_comb begin
    for (int b = 0; b < IDX_W; b++) laneMask[b] = (b < int'(logVl));
  end

  always_comb begin
    strobe      = '0;
    strobe.clr  = idle && startReq;
    strobe.acc  = take;
    strobe.fold = (state == ST_FOLD);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      remain  <= '0;
      lane    <= '0;
      logVl   <= '0;
      foldLog <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (startReq) begin
          logVl   <= logVlEff;
          foldLog <= logVlEff;
          remain  <= cfgCount;
          lane    <= '0;
          if (cfgCount != '0)      state <= ST_ACC;
          else if (logVlEff != '0) state <= ST_FOLD;
          else                     state <= ST_DONE;
        end
        ST_ACC: if (take) begin
          lane   <= (lane + 1'b1) & laneMask;
          remain <= remain - 1'b1;
          if (remain == CNT_W'(1)) state <= (logVl != '0) ? ST_FOLD : ST_DONE;
        end
        ST_FOLD: begin
          foldLog <= foldLog - 1'b1;
          if (foldLog == LV_W'(1)) state <= ST_DONE;
        end
        ST_DONE: if (resReady) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/stripSumPath.sv
`timescale 1ns/1ps
module stripSumPath
  import stripSumPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int VLMAX  = 8,
  parameter int IDX_W  = 3,
  parameter int LV_W   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  sumStrobe_t        strobe,
  input  logic [IDX_W-1:0]  lane,
  input  logic [LV_W-1:0]   foldLog,
  input  logic [DATA_W-1:0] inData,
  output logic [DATA_W-1:0] sumOut
);
  localparam int HALF_MAX = VLMAX / 2;

  logic [DATA_W-1:0] part    [VLMAX];
  logic [DATA_W-1:0] foldSum [HALF_MAX];
  logic [IDX_W-1:0]  half;

  // Distance between folded pairs in the current step
  assign half = IDX_W'(1) << (foldLog - 1'b1);

  for (genvar k = 0; k < HALF_MAX; k++) begin : gFold
    assign foldSum[k] = part[k] + part[IDX_W'(k) + half];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < VLMAX; k++) part[k] <= '0;
    end else if (strobe.clr) begin
      for (int k = 0; k < VLMAX; k++) part[k] <= '0;
    end else if (strobe.acc) begin
      part[lane] <= part[lane] + inData;
    end else if (strobe.fold) begin
      for (int k = 0; k < HALF_MAX; k++)
        if (IDX_W'(k) < half) part[k] <= foldSum[k];
    end
  end

  assign sumOut = part[0];
endmodule

// File: rtl/stripSumReduce.sv
`timescale 1ns/1ps
module stripSumReduce
  import stripSumPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int VLMAX  = 8,
  parameter int CNT_W  = 16,
  localparam int IDX_W = $clog2(VLMAX),
  localparam int LV_W  = $clog2(IDX_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [CNT_W-1:0]  cfgCount,
  input  logic [LV_W-1:0]   cfgLogVl,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  output logic              inReady,
  output logic              resValid,
  output logic [DATA_W-1:0] resData,
  input  logic              resReady
);
  sumStrobe_t       strobe;
  logic [IDX_W-1:0] lane;
  logic [LV_W-1:0]  foldLog;
  logic             ctrlIdle;

  stripSumCtrl #(.CNT_W(CNT_W), .IDX_W(IDX_W), .LV_W(LV_W)) ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .cfgCount(cfgCount),
    .cfgLogVl(cfgLogVl), .inValid(inValid), .resReady(resReady),
    .inReady(inReady), .resValid(resValid), .idle(ctrlIdle),
    .strobe(strobe), .lane(lane), .foldLog(foldLog)
  );

  stripSumPath #(.DATA_W(DATA_W), .VLMAX(VLMAX), .IDX_W(IDX_W), .LV_W(LV_W)) path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .lane(lane),
    .foldLog(foldLog), .inData(inData), .sumOut(resData)
  );
endmodule

// File: rtl/stripSumReduceChk.sv
`timescale 1ns/1ps
module stripSumReduceChk #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              startReq,
  input logic [CNT_W-1:0]  cfgCount,
  input logic              inReady,
  input logic              resValid,
  input logic [DATA_W-1:0] resData,
  input logic              resReady,
  input logic              idle
);
  assert_start_R1: assert property (@(posedge clk) disable iff (!rstN)
    idle && startReq && cfgCount != '0 |=> inReady);

  assert_empty_R6: assert property (@(posedge clk) disable iff (!rstN)
    idle && startReq && cfgCount == '0 |=> !inReady);

  assert_hold_result_R7: assert property (@(posedge clk) disable iff (!rstN)
    resValid && !resReady |=> resValid && $stable(resData));

  assert_release_R7: assert property (@(posedge clk) disable iff (!rstN)
    resValid && resReady |=> !resValid && idle);

  assert_no_overlap_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(inReady && resValid));

  assert_busy_ignores_R8: assert property (@(posedge clk) disable iff (!rstN)
    inReady && startReq |=> !idle);
endmodule

bind stripSumReduce stripSumReduceChk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) chk (
  .clk(clk), .rstN(rstN), .startReq(startReq), .cfgCount(cfgCount),
  .inReady(inReady), .resValid(resValid), .resData(resData),
  .resReady(resReady), .idle(ctrlIdle)
);

// File: tb/stripSumReduce_test.sv
`timescale 1ns/1ps
module stripSumReduce_test;
  localparam int DATA_W = 16;
  localparam int VLMAX  = 8;
  localparam int CNT_W  = 16;
  localparam int LV_W   = 2;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              startReq = 1'b0;
  logic [CNT_W-1:0]  cfgCount = '0;
  logic [LV_W-1:0]   cfgLogVl = '0;
  logic              inValid = 1'b0;
  logic [DATA_W-1:0] inData = '0;
  logic              inReady;
  logic              resValid;
  logic [DATA_W-1:0] resData;
  logic              resReady = 1'b0;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  stripSumReduce #(.DATA_W(DATA_W), .VLMAX(VLMAX), .CNT_W(CNT_W)) uut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .cfgCount(cfgCount),
    .cfgLogVl(cfgLogVl), .inValid(inValid), .inData(inData),
    .inReady(inReady), .resValid(resValid), .resData(resData),
    .resReady(resReady)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] elem(input int i, input int seed);
    return DATA_W'(32'hE001 + i * 4951 + seed * 257);
  endfunction

  task automatic runOne(input int n, input int lv, input int seed);
    logic [DATA_W-1:0] expSum = '0;
    logic [DATA_W-1:0] held;
    int lat;
    @(negedge clk);
    startReq = 1'b1; cfgCount = CNT_W'(n); cfgLogVl = LV_W'(lv);
    @(negedge clk);
    startReq = 1'b0;
    check(inReady == (n != 0), (n != 0) ? "R1 start" : "R6 empty start", int'(inReady), int'(n != 0));
    for (int i = 0; i < n; i++) begin
      if ((i + seed) % 3 == 1) begin
        inValid = 1'b0;
        // stray start with another configuration during accumulation: R8
        startReq = 1'b1; cfgCount = CNT_W'(3); cfgLogVl = '0;
        @(negedge clk);
        startReq = 1'b0;
      end
      if (!inReady) check(1'b0, "R2 ready during stream", 0, 1);
      inValid = 1'b1;
      inData  = elem(i, seed);
      expSum  = expSum + elem(i, seed);
      @(negedge clk);
    end
    // keep offering junk after the last element: R2 says it is not taken
    inValid = (n != 0);
    inData  = 16'h7777;
    lat = 0;
    while (!resValid && lat < 20) begin
      if (inReady) check(1'b0, "R2 ready after last", 1, 0);
      @(negedge clk);
      lat++;
    end
    inValid = 1'b0;
    if (n != 0) check(lat == lv, "R4 fold latency", lat, lv);
    check(resValid == 1'b1, "R7 result valid", int'(resValid), 1);
    check(resData == expSum, (n == 0) ? "R6 zero result" :
          ((n % (1 << lv)) != 0 ? "R5 short chunk sum" : "R3 sum"),
          int'(resData), int'(expSum));
    check(inReady == 1'b0, "R8 no input while result pending", int'(inReady), 0);
    held = resData;
    // start request while result is pending must be ignored: R8
    startReq = 1'b1; cfgCount = CNT_W'(5);
    @(negedge clk);
    startReq = 1'b0;
    @(negedge clk);
    check(resValid == 1'b1 && resData == held, "R7 hold", int'(resData), int'(held));
    resReady = 1'b1;
    @(negedge clk);
    resReady = 1'b0;
    check(resValid == 1'b0, "R7 release", int'(resValid), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R2 actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int seed = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(inReady == 1'b0, "R1 reset inReady", int'(inReady), 0);
    check(resValid == 1'b0, "R7 reset resValid", int'(resValid), 0);
    for (int lv = 0; lv <= 3; lv++) begin
      foreach (nList[j]) begin
        runOne(nList[j], lv, seed);
        seed++;
      end
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  int nList [11] = '{0, 1, 2, 3, 5, 7, 8, 9, 13, 16, 17};
endmodule